// File: doc/BRIEF.md
# Debug and Performance-Monitor Window Access Responder

This block answers single accesses arriving from an external debug bus. Each access names one of two register windows, either debug or performance monitor, with a 12-bit byte offset, a size code and a direction. The block replies one cycle later with an OK or error flag and read data. Three registers are implemented. Debug offset 0x080 holds a read/write scratch word. Debug offset 0x314 holds a status register of sticky event bits that a word read clears. Monitor offset 0xE04 holds a second scratch word. Every other offset is reserved.

What a reserved offset returns depends on layered conditions. The first layer is power and lock: the core domain is off, the double-lock is set, or the OS lock is set. The second layer is the permission flags for external debug and external monitor access, and each permission only covers certain offset spans. When no condition applies, a reserved offset reads as zero and ignores writes. The block also handles three corner cases in a fixed way: accesses that are not word sized, a write that meets a register reset in the same cycle, and clear-on-read while the double-lock is held.

Top module: `dbgwin_responder`

## Requirements
- R1: Every cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the next cycle. `rsp_valid` is never high otherwise.
- R2: A reserved debug-window access (`req_win`=0) at byte offset 0x000–0xCFF gives an error response when the core is unpowered (`core_pwr_on`=0), or `dbg_dlock`=1, or `dbg_oslock`=1.
- R3: Under the same three conditions, a reserved monitor-window access (`req_win`=1) at offset 0x000–0xF03 gives an error response.
- R4: With none of the R2 conditions present and `ext_dbg_allow`=0, reserved debug offsets 0x400–0x4FF and 0x800–0x8FF give an error. Other debug offsets, and the monitor window, are not affected by this flag.
- R5: With none of the R2 conditions present and `ext_pmu_allow`=0, reserved monitor offsets 0x000–0x0FF and 0x400–0x47F give an error. Other monitor offsets, and the debug window, are not affected by this flag.
- R6: A reserved offset covered by no error condition responds OK with zero data, and a write to it changes no register.
- R7: An error response always carries zero read data.
- R8: The implemented registers (debug 0x080, debug 0x314, monitor 0xE04) always respond OK. Word writes to a scratch register are read back unchanged.
- R9: An access that is not word sized (`req_size` other than 2'b10, where 0=byte, 1=half, 2=word) to an implemented register responds OK with zero data. It writes nothing and clears no status bit.
- R10: While `reg_reset` is high, both scratch registers take their reset values, even when a write to them arrives in the same cycle.
- R11: Each `sticky_set` bit sets the matching status bit, and the bit stays set. A word read of the status register returns its current value and then clears it.
- R12: While `core_pwr_on`=1 and `dbg_dlock`=1, reading the status register clears no bit.
- R13: A `sticky_set` bit that arrives in the same cycle as a clearing status read remains set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_win | input | 1 | Window select: 0 debug, 1 performance monitor |
| req_off | input | 12 | Byte offset inside the window |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | DATA_W | Write data |
| core_pwr_on | input | 1 | Core power domain on and accessible |
| dbg_dlock | input | 1 | Double-lock in force |
| dbg_oslock | input | 1 | OS lock in force |
| ext_dbg_allow | input | 1 | External debug access permitted |
| ext_pmu_allow | input | 1 | External monitor access permitted |
| reg_reset | input | 1 | Reset of the scratch registers |
| sticky_set | input | STAT_W | Event pulses that set status bits |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | DATA_W | Read data, zero on error |

## Verification
The reserved-offset rules are tested by sweeping the power-off, double-lock and OS-lock conditions one at a time. Span edges such as 0xCFC against 0xD00, 0xF00 against 0xF04, 0x4FC against 0x500 and 0x47C against 0x480 separate the correct boundary from one off by a word. Each permission flag is cleared alone and probed in both windows, which shows that each flag guards only its own window. Sticky-bit tests mix plain reads, byte reads, reads under double-lock and a set that lands on a clearing read, so clear suppression and set-over-clear priority appear as distinct outcomes.

// File: rtl/dbgwin_pkg.sv
package dbgwin_pkg;
  localparam int OFF_W = 12;
  typedef logic [OFF_W-1:0] off_t;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} size_e;
  typedef enum logic [1:0] {TGT_NONE, TGT_DSCR, TGT_DSTAT, TGT_PSCR} tgt_e;

  localparam off_t DSCR_OFF  = 12'h080;
  localparam off_t DSTAT_OFF = 12'h314;
  localparam off_t PSCR_OFF  = 12'hE04;

  // Inclusive byte span test.
  function automatic logic in_span(off_t a, off_t lo, off_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // First layer: power or lock makes the reserved space fault.
  function automatic logic gate_closed(logic pwr_on, logic dlock, logic oslock);
    return !pwr_on || dlock || oslock;
  endfunction

  function automatic logic dbg_lock_span(off_t a);
    return in_span(a, 12'h000, 12'hCFF);
  endfunction

  function automatic logic pmu_lock_span(off_t a);
    return in_span(a, 12'h000, 12'hF03);
  endfunction

  function automatic logic dbg_perm_span(off_t a);
    return in_span(a, 12'h400, 12'h4FF) || in_span(a, 12'h800, 12'h8FF);
  endfunction

  function automatic logic pmu_perm_span(off_t a);
    return in_span(a, 12'h000, 12'h0FF) || in_span(a, 12'h400, 12'h47F);
  endfunction

  // Layered fault decision for a reserved offset.
  function automatic logic rsv_fault(logic win_pmu, off_t a, logic pwr_on, logic dlock,
                                     logic oslock, logic dbg_ok, logic pmu_ok);
    logic closed;
    closed = gate_closed(pwr_on, dlock, oslock);
    if (win_pmu) begin
      if (closed) return pmu_lock_span(a);
      return !pmu_ok && pmu_perm_span(a);
    end
    if (closed) return dbg_lock_span(a);
    return !dbg_ok && dbg_perm_span(a);
  endfunction
endpackage

// File: rtl/dbgwin_decode.sv
module dbgwin_decode
  import dbgwin_pkg::*;
(
  input  logic win_pmu,
  input  off_t off,
  input  logic pwr_on,
  input  logic dlock,
  input  logic oslock,
  input  logic dbg_ok,
  input  logic pmu_ok,
  output tgt_e tgt,
  output logic reserved,
  output logic rsv_err
);
  always_comb begin
    tgt = TGT_NONE;
    if (!win_pmu && off == DSCR_OFF)  tgt = TGT_DSCR;
    if (!win_pmu && off == DSTAT_OFF) tgt = TGT_DSTAT;
    if (win_pmu  && off == PSCR_OFF)  tgt = TGT_PSCR;
  end

  assign reserved = (tgt == TGT_NONE);
  assign rsv_err  = reserved && rsv_fault(win_pmu, off, pwr_on, dlock, oslock, dbg_ok, pmu_ok);
endmodule

// File: rtl/dbgwin_regs.sv
module dbgwin_regs #(
  parameter int          DATA_W   = 32,
  parameter int          STAT_W   = 8,
  parameter logic [DATA_W-1:0] DSCR_RST = '0,
  parameter logic [DATA_W-1:0] PSCR_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_reset,
  input  logic              wr_dscr,
  input  logic              wr_pscr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STAT_W-1:0] stat_set,
  input  logic              stat_clr,
  output logic [DATA_W-1:0] dscr_q,
  output logic [DATA_W-1:0] pscr_q,
  output logic [STAT_W-1:0] status_q
);
  logic [STAT_W-1:0] stat_keep;
  assign stat_keep = stat_clr ? '0 : status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dscr_q   <= DSCR_RST;
      pscr_q   <= PSCR_RST;
      status_q <= '0;
    end else begin
      if (reg_reset)    dscr_q <= DSCR_RST;
      else if (wr_dscr) dscr_q <= wdata;
      if (reg_reset)    pscr_q <= PSCR_RST;
      else if (wr_pscr) pscr_q <= wdata;
      status_q <= stat_keep | stat_set;
    end
  end
endmodule

// File: rtl/dbgwin_rsp.sv
module dbgwin_rsp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              err,
  input  logic [DATA_W-1:0] rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= fire;
      rsp_err   <= fire && err;
      rsp_rdata <= (fire && !err) ? rdata : '0;
    end
  end
endmodule

// File: rtl/dbgwin_responder.sv
module dbgwin_responder
  import dbgwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 8,
  parameter logic [DATA_W-1:0] DSCR_RST = 32'h1234_0000,
  parameter logic [DATA_W-1:0] PSCR_RST = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_win,
  input  logic [11:0]       req_off,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              core_pwr_on,
  input  logic              dbg_dlock,
  input  logic              dbg_oslock,
  input  logic              ext_dbg_allow,
  input  logic              ext_pmu_allow,
  input  logic              reg_reset,
  input  logic [STAT_W-1:0] sticky_set,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  tgt_e              tgt;
  logic              rsv_hit;
  logic              rsv_err;
  logic              is_word;
  logic              wr_fire;
  logic              rd_fire;
  logic              clr_block;
  logic              stat_clr;
  logic [DATA_W-1:0] dscr_q;
  logic [DATA_W-1:0] pscr_q;
  logic [STAT_W-1:0] status_q;
  logic [DATA_W-1:0] stat_ext;
  logic [DATA_W-1:0] rd_value;

  dbgwin_decode u_dec (
    .win_pmu (req_win),
    .off     (off_t'(req_off)),
    .pwr_on  (core_pwr_on),
    .dlock   (dbg_dlock),
    .oslock  (dbg_oslock),
    .dbg_ok  (ext_dbg_allow),
    .pmu_ok  (ext_pmu_allow),
    .tgt     (tgt),
    .reserved(rsv_hit),
    .rsv_err (rsv_err)
  );

  assign is_word   = (size_e'(req_size) == SZ_WORD);
  assign wr_fire   = req_valid && req_write && is_word;
  assign rd_fire   = req_valid && !req_write && is_word;
  assign clr_block = core_pwr_on && dbg_dlock;
  assign stat_clr  = rd_fire && (tgt == TGT_DSTAT) && !clr_block;

  dbgwin_regs #(
    .DATA_W  (DATA_W),
    .STAT_W  (STAT_W),
    .DSCR_RST(DSCR_RST),
    .PSCR_RST(PSCR_RST)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_reset(reg_reset),
    .wr_dscr (wr_fire && (tgt == TGT_DSCR)),
    .wr_pscr (wr_fire && (tgt == TGT_PSCR)),
    .wdata   (req_wdata),
    .stat_set(sticky_set),
    .stat_clr(stat_clr),
    .dscr_q  (dscr_q),
    .pscr_q  (pscr_q),
    .status_q(status_q)
  );

  generate
    if (DATA_W > STAT_W) begin : g_stat_pad
      assign stat_ext = {{(DATA_W-STAT_W){1'b0}}, status_q};
    end else begin : g_stat_flat
      assign stat_ext = status_q[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    rd_value = '0;
    if (is_word && !req_write) begin
      case (tgt)
        TGT_DSCR:  rd_value = dscr_q;
        TGT_DSTAT: rd_value = stat_ext;
        TGT_PSCR:  rd_value = pscr_q;
        default:   rd_value = '0;
      endcase
    end
  end

  dbgwin_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (req_valid),
    .err      (rsv_err),
    .rdata    (rd_value),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/dbgwin_checker.sv
module dbgwin_checker #(
  parameter int DATA_W = 32,
  parameter int STAT_W = 8,
  parameter logic [DATA_W-1:0] DSCR_RST = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_win,
  input logic [11:0]       req_off,
  input logic              core_pwr_on,
  input logic              dbg_dlock,
  input logic              dbg_oslock,
  input logic              reg_reset,
  input logic [STAT_W-1:0] sticky_set,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsv_hit,
  input logic [DATA_W-1:0] dscr_q,
  input logic [STAT_W-1:0] status_q
);
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
  a_r2_dbg_lock_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_win && rsv_hit && req_off <= 12'hCFF &&
     (!core_pwr_on || dbg_dlock || dbg_oslock)) |=> rsp_err);
  a_r6_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsv_hit) |=> (rsp_rdata == '0));
  a_r10_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reg_reset |=> (dscr_q == DSCR_RST));
  a_r12_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr_on && dbg_dlock) |=> ((status_q & $past(status_q)) == $past(status_q)));
  a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_set != '0) |=> ((status_q & $past(sticky_set)) == $past(sticky_set)));
endmodule

bind dbgwin_responder dbgwin_checker #(
  .DATA_W  (DATA_W),
  .STAT_W  (STAT_W),
  .DSCR_RST(DSCR_RST)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_win    (req_win),
  .req_off    (req_off),
  .core_pwr_on(core_pwr_on),
  .dbg_dlock  (dbg_dlock),
  .dbg_oslock (dbg_oslock),
  .reg_reset  (reg_reset),
  .sticky_set (sticky_set),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_rdata  (rsp_rdata),
  .rsv_hit    (rsv_hit),
  .dscr_q     (dscr_q),
  .status_q   (status_q)
);

// File: tb/tb_dbgwin_responder.sv
module tb_dbgwin_responder;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int SW = 8;
  localparam logic [DW-1:0] DSCR_RST = 32'h1234_0000;
  localparam logic [DW-1:0] PSCR_RST = 32'h0000_0000;
  localparam logic [1:0] BYTE = 2'd0;
  localparam logic [1:0] WORD = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_win = 1'b0, req_write = 1'b0;
  logic [11:0] req_off = '0;
  logic [1:0] req_size = WORD;
  logic [DW-1:0] req_wdata = '0;
  logic core_pwr_on = 1'b1, dbg_dlock = 1'b0, dbg_oslock = 1'b0;
  logic ext_dbg_allow = 1'b1, ext_pmu_allow = 1'b1, reg_reset = 1'b0;
  logic [SW-1:0] sticky_set = '0;
  logic rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;

  logic [SW-1:0] pend_set = '0;
  logic pend_rst = 1'b0;
  logic got_v, got_e;
  logic [DW-1:0] got_d;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgwin_responder #(.DATA_W(DW), .STAT_W(SW), .DSCR_RST(DSCR_RST), .PSCR_RST(PSCR_RST)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_win(req_win), .req_off(req_off),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .core_pwr_on(core_pwr_on), .dbg_dlock(dbg_dlock), .dbg_oslock(dbg_oslock),
    .ext_dbg_allow(ext_dbg_allow), .ext_pmu_allow(ext_pmu_allow), .reg_reset(reg_reset),
    .sticky_set(sticky_set), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access; the response is sampled at the negedge after the capturing edge.
  task automatic access(input logic win, input logic [11:0] off, input logic [1:0] sz,
                        input logic wr, input logic [DW-1:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_win = win; req_off = off; req_size = sz;
    req_write = wr; req_wdata = wd; sticky_set = pend_set; reg_reset = pend_rst;
    @(negedge clk);
    req_valid = 1'b0; sticky_set = '0; reg_reset = 1'b0;
    got_v = rsp_valid; got_e = rsp_err; got_d = rsp_rdata;
    chk("R1 rsp_valid", {31'b0, got_v}, 32'd1);
  endtask

  task automatic expect_rd(input string tag, input logic win, input logic [11:0] off,
                           input logic err, input logic [DW-1:0] data);
    access(win, off, WORD, 1'b0, '0);
    chk({tag, " err"}, {31'b0, got_e}, {31'b0, err});
    chk({tag, " data"}, got_d, data);
  endtask

  task automatic pulse_set(input logic [SW-1:0] bits);
    @(negedge clk); sticky_set = bits;
    @(negedge clk); sticky_set = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 idle after reset", {31'b0, rsp_valid}, 32'd0);
    expect_rd("R10 dscr reset value", 1'b0, 12'h080, 1'b0, DSCR_RST);
  endtask

  task automatic t_scratch;
    access(1'b0, 12'h080, WORD, 1'b1, 32'hCAFE_0001);
    chk("R8 write ok", {31'b0, got_e}, 32'd0);
    expect_rd("R8 dscr", 1'b0, 12'h080, 1'b0, 32'hCAFE_0001);
    access(1'b1, 12'hE04, WORD, 1'b1, 32'h0BAD_F00D);
    expect_rd("R8 pscr", 1'b1, 12'hE04, 1'b0, 32'h0BAD_F00D);
    core_pwr_on = 1'b0; dbg_oslock = 1'b1;
    expect_rd("R8 dscr under lock", 1'b0, 12'h080, 1'b0, 32'hCAFE_0001);
    core_pwr_on = 1'b1; dbg_oslock = 1'b0;
  endtask

  task automatic t_lock;
    core_pwr_on = 1'b0;
    expect_rd("R2 pwr off 0x400", 1'b0, 12'h400, 1'b1, '0);
    expect_rd("R3 pwr off pmu 0x000", 1'b1, 12'h000, 1'b1, '0);
    core_pwr_on = 1'b1; dbg_dlock = 1'b1;
    expect_rd("R2 dlock 0x200", 1'b0, 12'h200, 1'b1, '0);
    access(1'b0, 12'h200, WORD, 1'b1, 32'hFFFF_FFFF);
    chk("R7 write err data zero", got_d, '0);
    chk("R2 write err", {31'b0, got_e}, 32'd1);
    dbg_dlock = 1'b0; dbg_oslock = 1'b1;
    expect_rd("R2 oslock 0xCFC", 1'b0, 12'hCFC, 1'b1, '0);
    expect_rd("R6 oslock 0xD00", 1'b0, 12'hD00, 1'b0, '0);
    expect_rd("R3 oslock pmu 0xF00", 1'b1, 12'hF00, 1'b1, '0);
    expect_rd("R6 oslock pmu 0xF04", 1'b1, 12'hF04, 1'b0, '0);
    dbg_oslock = 1'b0;
    expect_rd("R6 open 0x200", 1'b0, 12'h200, 1'b0, '0);
  endtask

  task automatic t_perm;
    ext_dbg_allow = 1'b0;
    expect_rd("R4 0x4FC", 1'b0, 12'h4FC, 1'b1, '0);
    expect_rd("R4 0x800", 1'b0, 12'h800, 1'b1, '0);
    expect_rd("R4 0x500", 1'b0, 12'h500, 1'b0, '0);
    expect_rd("R4 0x900", 1'b0, 12'h900, 1'b0, '0);
    expect_rd("R4 pmu 0x400 unaffected", 1'b1, 12'h400, 1'b0, '0);
    ext_dbg_allow = 1'b1; ext_pmu_allow = 1'b0;
    expect_rd("R5 0x0FC", 1'b1, 12'h0FC, 1'b1, '0);
    expect_rd("R5 0x47C", 1'b1, 12'h47C, 1'b1, '0);
    expect_rd("R5 0x480", 1'b1, 12'h480, 1'b0, '0);
    expect_rd("R5 0x800", 1'b1, 12'h800, 1'b0, '0);
    expect_rd("R5 dbg 0x400 unaffected", 1'b0, 12'h400, 1'b0, '0);
    ext_pmu_allow = 1'b1;
  endtask

  task automatic t_raz;
    access(1'b0, 12'h600, WORD, 1'b1, 32'h5555_AAAA);
    chk("R6 write ok", {31'b0, got_e}, 32'd0);
    expect_rd("R6 read back zero", 1'b0, 12'h600, 1'b0, '0);
    expect_rd("R6 dscr untouched", 1'b0, 12'h080, 1'b0, 32'hCAFE_0001);
  endtask

  task automatic t_subword;
    access(1'b0, 12'h080, BYTE, 1'b1, 32'h0000_00EE);
    chk("R9 byte write ok", {31'b0, got_e}, 32'd0);
    access(1'b0, 12'h080, BYTE, 1'b0, '0);
    chk("R9 byte read data", got_d, '0);
    expect_rd("R9 dscr unchanged", 1'b0, 12'h080, 1'b0, 32'hCAFE_0001);
    pulse_set(8'h05);
    access(1'b0, 12'h314, BYTE, 1'b0, '0);
    chk("R9 byte status read ok", {31'b0, got_e}, 32'd0);
    expect_rd("R9 status kept", 1'b0, 12'h314, 1'b0, 32'h05);
    expect_rd("R11 cleared", 1'b0, 12'h314, 1'b0, 32'h00);
  endtask

  task automatic t_collide;
    pend_rst = 1'b1;
    access(1'b0, 12'h080, WORD, 1'b1, 32'h7777_7777);
    pend_rst = 1'b0;
    expect_rd("R10 dscr reset wins", 1'b0, 12'h080, 1'b0, DSCR_RST);
    access(1'b1, 12'hE04, WORD, 1'b1, 32'h0000_1111);
    pend_rst = 1'b1;
    access(1'b1, 12'hE04, WORD, 1'b1, 32'h0000_2222);
    pend_rst = 1'b0;
    expect_rd("R10 pscr reset wins", 1'b1, 12'hE04, 1'b0, PSCR_RST);
  endtask

  task automatic t_sticky;
    pulse_set(8'h81);
    pulse_set(8'h10);
    expect_rd("R11 accumulated", 1'b0, 12'h314, 1'b0, 32'h91);
    expect_rd("R11 cleared after read", 1'b0, 12'h314, 1'b0, 32'h00);
    pulse_set(8'h02);
    pend_set = 8'h40;
    expect_rd("R13 read returns old", 1'b0, 12'h314, 1'b0, 32'h02);
    pend_set = '0;
    expect_rd("R13 set survives clear", 1'b0, 12'h314, 1'b0, 32'h40);
  endtask

  task automatic t_dlock_keep;
    pulse_set(8'h24);
    dbg_dlock = 1'b1;
    expect_rd("R12 read under dlock", 1'b0, 12'h314, 1'b0, 32'h24);
    expect_rd("R12 not cleared", 1'b0, 12'h314, 1'b0, 32'h24);
    core_pwr_on = 1'b0;
    expect_rd("R11 off+dlock read", 1'b0, 12'h314, 1'b0, 32'h24);
    expect_rd("R11 off+dlock cleared", 1'b0, 12'h314, 1'b0, 32'h00);
    core_pwr_on = 1'b1; dbg_dlock = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_scratch();
    t_lock();
    t_perm();
    t_raz();
    t_subword();
    t_collide();
    t_sticky();
    t_dlock_keep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule